// File: doc/BRIEF.md
# Paged Serial EEPROM Block Transfer Sequencer

This block is an SPI master that moves a block of bytes of any length, starting at any 16-bit address, into a serial EEPROM whose array is organised in 32-byte pages. Source bytes come from a valid/ready stream. The sequencer splits the block wherever the address crosses a page boundary. Before each piece it sends a separate write-enable frame. After each piece it polls the device's busy flag, with a retry limit, and only then moves on. After the last piece it sends a write-disable frame and pulses `done`.

The same engine also has two other modes. A block read streams received bytes out on `rd_data`/`rd_valid`. A status write sends one byte to the device's status register after a write-enable frame. SCK comes from the system clock through a parameterised divider. Frames use SPI mode 0 and shift the most significant bit first.

A host pulses `start` with an operation code, address, byte count and, for status writes, the status byte. It then waits for `done`, or for `error` if the device never reported idle.

Top module: `spi_eeprom_seq`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low and `op` is 0 (block write), 1 (block read) or 2 (status write). A pulse while busy, or with `op` = 3, changes nothing at the ports.
- R2: The bus runs in SPI mode 0 with MSB first. SCK is low whenever `cs_n` is high, each SCK half period lasts DIV_HALF clocks, MOSI changes only while SCK is low, and MISO is sampled on the SCK rising edge.
- R3: Every write piece starts with a frame carrying only opcode 0x06, followed by CS high. Then a frame carries opcode 0x02, the address high byte, the address low byte and the data bytes.
- R4: A write piece closes after the last byte of the block, or after the byte whose address has its low five bits all ones. No piece crosses a 32-byte page.
- R5: After each piece the sequencer sends status frames. Each one is opcode 0x05 followed by one dummy 0x00 byte. They repeat until bit 0 of the returned byte is 0. Only then does the next piece, or the disable frame, begin.
- R6: If POLL_MAX (default 50) status frames in a row all return bit 0 set, `error` rises. At the same time `cs_n` is high and `busy` drops, and no further frame and no `done` follow. `error` clears at the next accepted start.
- R7: After the final piece reports idle, a frame carrying only opcode 0x04 is sent, then `done` pulses.
- R8: A block read is one frame: opcode 0x03, the address high byte, the address low byte, then one dummy 0x00 byte per requested byte. Each received byte appears on `rd_data` with a one-cycle `rd_valid`, and CS stays low from the opcode to the last byte.
- R9: A status write sends a frame with only 0x06, then a frame with opcode 0x01 and `stat_byte`, then pulses `done` without polling.
- R10: `done` is a one-cycle pulse in the cycle `busy` falls. `wr_ready` is high only while CS is low in the data phase, and exactly `count` stream bytes are consumed.
- R11: After reset `cs_n` is high, and `sck`, `busy`, `done`, `error`, `rd_valid` and `wr_ready` are low.
- R12: A block write or read with `count` = 0 sends no frame and pulses `done` one cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| op | input | 2 | Operation: 0 write, 1 read, 2 status write, 3 reserved |
| addr | input | 16 | Start address |
| count | input | CNT_W | Number of bytes |
| stat_byte | input | 8 | Byte sent by a status write |
| wr_data | input | 8 | Source stream data |
| wr_valid | input | 1 | Source stream valid |
| wr_ready | output | 1 | Source stream ready |
| rd_data | output | 8 | Byte received by a block read |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Busy-poll limit exhausted |
| cs_n | output | 1 | Device chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |

## Verification
Most internal faults show up on the bus within one byte time (16 × DIV_HALF clocks). Examples are a wrong page-boundary test, a stale address after a piece, or a missed poll result. The scoreboard sees a frame closing early or late, a wrong address byte, or a status frame where a write-enable frame was due. A broken poll counter only appears after the fiftieth busy reply, as an extra frame or a missing `error`. Read-path faults show up on `rd_data` one cycle after the last SCK falling edge of each byte.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_READ   = 2'd1,
    OP_STATUS = 2'd2,
    OP_RSVD   = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WREN,
    S_WREN_GAP,
    S_CMD,
    S_ADH,
    S_ADL,
    S_WDATA,
    S_SEG_GAP,
    S_POLL_CMD,
    S_POLL_RD,
    S_POLL_GAP,
    S_WRDI,
    S_RDATA,
    S_ST_DATA,
    S_FIN
  } seq_state_e;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;

  // True when an address is the first byte of a page of 2**pbits bytes.
  function automatic logic page_start(input logic [15:0] a, input int unsigned pbits);
    logic [15:0] mask;
    mask = (16'd1 << pbits) - 16'd1;
    return (a & mask) == 16'd0;
  endfunction

  // States in which chip select is held low.
  function automatic logic in_frame(input seq_state_e s);
    case (s)
      S_WREN, S_CMD, S_ADH, S_ADL, S_WDATA, S_POLL_CMD, S_POLL_RD,
      S_WRDI, S_RDATA, S_ST_DATA: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DIV_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       fin
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic          phase_q, act_q, fin_q;
  logic [7:0]    tx_q, rx_q;

  wire half_tick = act_q && (div_q == DW'(DIV_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; bit_q <= '0; phase_q <= 1'b0; act_q <= 1'b0;
      fin_q <= 1'b0; tx_q <= '0; rx_q <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go && !act_q) begin
        act_q <= 1'b1; tx_q <= tx; div_q <= '0; bit_q <= '0; phase_q <= 1'b0;
      end else if (act_q) begin
        if (half_tick) begin
          div_q <= '0;
          if (!phase_q) begin
            phase_q <= 1'b1;
            rx_q    <= {rx_q[6:0], miso};
          end else begin
            phase_q <= 1'b0;
            if (bit_q == 3'd7) begin
              act_q <= 1'b0;
              fin_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  assign sck  = phase_q;
  assign mosi = tx_q[7];
  assign rx   = rx_q;
  assign fin  = fin_q;

  // R2: data line held across the whole high half of SCK
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  // R2: the sequencer never launches a byte while one is shifting
  p_go_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !sck);
  p_fin_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
  import spi_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 5,
  parameter int POLL_MAX  = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [15:0]      addr,
  input  logic [CNT_W-1:0] count,
  input  logic [7:0]       stat_byte,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             cs_n,
  output logic             sh_go,
  output logic [7:0]       sh_tx,
  input  logic             sh_fin,
  input  logic [7:0]       sh_rx
);
  localparam int PW = $clog2(POLL_MAX + 1);

  seq_state_e       state_q;
  op_e              mode_q;
  logic [15:0]      addr_q;
  logic [CNT_W-1:0] rem_q;
  logic [7:0]       stat_q;
  logic [PW-1:0]    poll_q;
  logic             dev_busy_q;
  logic             inflight_q;
  logic             done_q, err_q, rdv_q;
  logic [7:0]       rdd_q;
  logic [7:0]       tx_sel;

  // Named internal events
  wire start_ok   = (state_q == S_IDLE) && start && (op_e'(op) != OP_RSVD);
  wire byte_end   = inflight_q && sh_fin;
  wire last_byte  = (rem_q == CNT_W'(1));
  wire seg_close  = (state_q == S_WDATA) && byte_end &&
                    (last_byte || page_start(addr_q + 16'd1, PAGE_BITS));
  wire poll_idle  = (state_q == S_POLL_GAP) && !dev_busy_q;
  wire poll_quit  = (state_q == S_POLL_GAP) && dev_busy_q && (poll_q == PW'(POLL_MAX - 1));
  wire fire       = in_frame(state_q) && !inflight_q &&
                    ((state_q != S_WDATA) || wr_valid);

  always_comb begin
    case (state_q)
      S_WREN:     tx_sel = OPC_WREN;
      S_CMD:      tx_sel = (mode_q == OP_WRITE) ? OPC_WRITE :
                           (mode_q == OP_READ)  ? OPC_READ  : OPC_WRSR;
      S_ADH:      tx_sel = addr_q[15:8];
      S_ADL:      tx_sel = addr_q[7:0];
      S_POLL_CMD: tx_sel = OPC_RDSR;
      S_WRDI:     tx_sel = OPC_WRDI;
      S_ST_DATA:  tx_sel = stat_q;
      default:    tx_sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; mode_q <= OP_WRITE; addr_q <= '0; rem_q <= '0;
      stat_q <= '0; poll_q <= '0; dev_busy_q <= 1'b0; inflight_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; rdv_q <= 1'b0; rdd_q <= '0;
      sh_go <= 1'b0; sh_tx <= '0;
    end else begin
      sh_go  <= 1'b0;
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      if (fire) begin
        sh_go      <= 1'b1;
        sh_tx      <= (state_q == S_WDATA) ? wr_data : tx_sel;
        inflight_q <= 1'b1;
      end
      if (byte_end) inflight_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_ok) begin
          err_q  <= 1'b0;
          mode_q <= op_e'(op);
          addr_q <= addr;
          rem_q  <= count;
          stat_q <= stat_byte;
          if (op_e'(op) != OP_STATUS && count == '0) done_q <= 1'b1;
          else state_q <= (op_e'(op) == OP_READ) ? S_CMD : S_WREN;
        end
        S_WREN:     if (byte_end) state_q <= S_WREN_GAP;
        S_WREN_GAP: state_q <= S_CMD;
        S_CMD:      if (byte_end) state_q <= (mode_q == OP_STATUS) ? S_ST_DATA : S_ADH;
        S_ADH:      if (byte_end) state_q <= S_ADL;
        S_ADL:      if (byte_end) state_q <= (mode_q == OP_WRITE) ? S_WDATA : S_RDATA;
        S_WDATA: if (byte_end) begin
          addr_q <= addr_q + 16'd1;
          rem_q  <= rem_q - CNT_W'(1);
          if (seg_close) state_q <= S_SEG_GAP;
        end
        S_SEG_GAP: begin
          poll_q  <= '0;
          state_q <= S_POLL_CMD;
        end
        S_POLL_CMD: if (byte_end) state_q <= S_POLL_RD;
        S_POLL_RD: if (byte_end) begin
          dev_busy_q <= sh_rx[0];
          state_q    <= S_POLL_GAP;
        end
        S_POLL_GAP: begin
          if (poll_idle) state_q <= (rem_q == '0) ? S_WRDI : S_WREN;
          else if (poll_quit) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            poll_q  <= poll_q + PW'(1);
            state_q <= S_POLL_CMD;
          end
        end
        S_WRDI: if (byte_end) state_q <= S_FIN;
        S_RDATA: if (byte_end) begin
          rdd_q <= sh_rx;
          rdv_q <= 1'b1;
          rem_q <= rem_q - CNT_W'(1);
          if (last_byte) state_q <= S_FIN;
        end
        S_ST_DATA: if (byte_end) state_q <= S_FIN;
        S_FIN: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign wr_ready = (state_q == S_WDATA) && !inflight_q;
  assign rd_data  = rdd_q;
  assign rd_valid = rdv_q;
  assign busy     = (state_q != S_IDLE);
  assign done     = done_q;
  assign error    = err_q;
  assign cs_n     = !in_frame(state_q);

  // R1: a pulse during an operation leaves the latched operation alone
  p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_q) && $stable(stat_q));
  // R4: the byte at the last address of a page always closes the piece
  p_page_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_WDATA) && byte_end &&
     (addr_q[PAGE_BITS-1:0] == {PAGE_BITS{1'b1}})) |=> (state_q == S_SEG_GAP));
  // R5: a new write-enable frame only follows an idle status reply
  p_wren_after_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_WREN) && $past(state_q == S_POLL_GAP)) |-> !dev_busy_q);
  // R6: poll counter stays inside its limit
  p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q < PW'(POLL_MAX));
  // R8: one strobe per received byte
  p_rd_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R10: stream accepted only inside an open frame with bytes left
  p_ready_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!cs_n && rem_q != '0));
endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq #(
  parameter int DIV_HALF  = 2,
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 5,
  parameter int POLL_MAX  = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [15:0]      addr,
  input  logic [CNT_W-1:0] count,
  input  logic [7:0]       stat_byte,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             cs_n,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  logic       sh_go, sh_fin;
  logic [7:0] sh_tx, sh_rx;

  spi_seq_fsm #(
    .CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS), .POLL_MAX(POLL_MAX)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .count(count), .stat_byte(stat_byte), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .done(done), .error(error),
    .cs_n(cs_n), .sh_go(sh_go), .sh_tx(sh_tx), .sh_fin(sh_fin), .sh_rx(sh_rx)
  );

  spi_byte_shifter #(.DIV_HALF(DIV_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx(sh_tx), .miso(miso),
    .sck(sck), .mosi(mosi), .rx(sh_rx), .fin(sh_fin)
  );

  // R2: clock parked low while deselected
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  // R6: an error leaves the bus released and the block idle
  p_err_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!busy && cs_n && !done));
  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/spi_eeprom_seq_tb.sv
module spi_eeprom_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [15:0] addr = 16'd0, count = 16'd0;
  logic [7:0]  stat_byte = 8'd0, wr_data = 8'd0;
  logic        wr_valid = 1'b0, miso = 1'b0;
  wire         wr_ready, rd_valid, busy, done, error, cs_n, sck, mosi;
  wire [7:0]   rd_data;

  spi_eeprom_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .count(count), .stat_byte(stat_byte), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .done(done), .error(error),
    .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit rst_done = 0, hs = 0;
  logic [8:0] expq[$];
  logic [7:0] srcq[$];
  logic [7:0] rdq[$];
  int busy_cfg = 0, busy_left = 0;
  int dv_bits = 0, dv_idx = 0;
  logic [7:0] dv_rx = 0, dv_cmd = 0, dv_next = 0, dv_sh = 0;
  logic [15:0] dv_addr = 0;

  function automatic logic [7:0] dat(int k);
    return 8'(k * 7 + 3);
  endfunction
  function automatic logic [7:0] mem_pat(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sb_take(logic [8:0] item);
    logic [8:0] e;
    if (expq.size() == 0) chk(0, "R3 R5 R7 R8 R9 unexpected bus item", int'(item), 9'h1ff);
    else begin
      e = expq.pop_front();
      chk(e == item, "R3 R4 R5 R7 R8 R9 bus stream", int'(item), int'(e));
    end
  endtask

  task automatic push(logic [7:0] b); expq.push_back({1'b0, b}); endtask
  task automatic push_end(); expq.push_back(9'h100); endtask

  // Expected bus traffic of a block write: pieces cut by modulo page arithmetic
  task automatic gen_write(input logic [15:0] a, input int n, input int bz);
    int rem; int k; int seg; int polls; logic [15:0] p;
    rem = n; k = 0; p = a;
    while (rem > 0) begin
      seg = 32 - int'(p % 16'd32);
      if (seg > rem) seg = rem;
      push(8'h06); push_end();
      push(8'h02); push(p[15:8]); push(p[7:0]);
      for (int i = 0; i < seg; i++) begin
        push(dat(k)); srcq.push_back(dat(k)); k++;
      end
      push_end();
      p = p + 16'(seg);
      rem = rem - seg;
      polls = (bz >= 50) ? 50 : bz + 1;
      for (int i = 0; i < polls; i++) begin push(8'h05); push(8'h00); push_end(); end
      if (bz >= 50) return;
    end
    push(8'h04); push_end();
  endtask

  task automatic start_op(input logic [1:0] o, input logic [15:0] a,
                          input logic [15:0] n, input logic [7:0] s);
    @(negedge clk);
    op = o; addr = a; count = n; stat_byte = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input bit expect_done, input string req);
    int guard;
    guard = 0;
    while (busy && guard < 100000) begin @(negedge clk); guard++; end
    chk(done == expect_done, req, done, expect_done);
    @(negedge clk);
    chk(done == 1'b0, "R10 done lasts one cycle", done, 0);
  endtask

  // Device model: SPI mode 0 slave with a busy flag
  always @(negedge cs_n) if (rst_done) begin
    dv_bits = 0; dv_idx = 0; dv_next = 8'h00; miso = 1'b0;
  end
  always @(posedge sck) if (rst_done) begin
    dv_rx = {dv_rx[6:0], mosi};
    dv_bits++;
    if (dv_bits == 8) begin
      dv_bits = 0;
      sb_take({1'b0, dv_rx});
      if (dv_idx == 0) dv_cmd = dv_rx;
      else if (dv_idx == 1) dv_addr[15:8] = dv_rx;
      else if (dv_idx == 2) dv_addr[7:0] = dv_rx;
      if (dv_cmd == 8'h05) dv_next = (busy_left > 0) ? 8'h01 : 8'h00;
      else if (dv_cmd == 8'h03 && dv_idx >= 2) dv_next = mem_pat(dv_addr + 16'(dv_idx - 2));
      else dv_next = 8'h00;
      dv_idx++;
    end
  end
  always @(negedge sck) if (rst_done) begin
    if (dv_bits == 0) begin miso = dv_next[7]; dv_sh = {dv_next[6:0], 1'b0}; end
    else begin miso = dv_sh[7]; dv_sh = {dv_sh[6:0], 1'b0}; end
  end
  always @(posedge cs_n) if (rst_done) begin
    sb_take(9'h100);
    if (dv_bits != 0) chk(0, "R2 frame ends on byte boundary", dv_bits, 0);
    if (dv_cmd == 8'h02 && dv_idx > 0) busy_left = busy_cfg;
    else if (dv_cmd == 8'h05 && busy_left > 0) busy_left--;
    dv_cmd = 8'h00;
  end

  // Source stream driver and output monitors
  always @(negedge clk) begin
    if (hs) void'(srcq.pop_front());
    wr_valid = (srcq.size() > 0);
    wr_data  = wr_valid ? srcq[0] : 8'h00;
    hs = wr_valid && wr_ready;
    if (rst_done && wr_ready && cs_n) chk(0, "R10 ready outside frame", 1, 0);
    if (rst_done && sck && cs_n) chk(0, "R2 sck high while deselected", 1, 0);
  end
  always @(negedge clk) if (rst_done && rd_valid) begin
    logic [7:0] e;
    if (rdq.size() == 0) chk(0, "R8 unexpected rd_valid", rd_data, 0);
    else begin
      e = rdq.pop_front();
      chk(rd_data == e, "R8 read data", rd_data, e);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rst_done = 1;
    @(negedge clk);
    // R11 reset state
    chk(cs_n == 1'b1, "R11 cs_n", cs_n, 1);
    chk(sck == 1'b0 && busy == 1'b0, "R11 sck/busy", {sck, busy}, 0);
    chk(done == 1'b0 && error == 1'b0, "R11 done/error", {done, error}, 0);
    chk(rd_valid == 1'b0 && wr_ready == 1'b0, "R11 strobes", {rd_valid, wr_ready}, 0);

    // R3 R4 R5 R7: unaligned write spanning two pages, device busy twice
    busy_cfg = 2;
    gen_write(16'h0105, 35, 2);
    start_op(2'd0, 16'h0105, 16'd35, 8'h00);
    chk(busy == 1'b1, "R1 start accepted", busy, 1);
    wait_idle(1, "R7 done after disable frame");
    chk(expq.size() == 0, "R4 R5 stream complete", expq.size(), 0);
    chk(srcq.size() == 0, "R10 all bytes consumed", srcq.size(), 0);

    // R4: exactly one aligned full page
    busy_cfg = 0;
    gen_write(16'h00E0, 32, 0);
    start_op(2'd0, 16'h00E0, 16'd32, 8'h00);
    wait_idle(1, "R4 aligned page done");
    chk(expq.size() == 0, "R4 aligned page stream", expq.size(), 0);

    // R4: single byte at last address of a page
    busy_cfg = 1;
    gen_write(16'h001F, 1, 1);
    start_op(2'd0, 16'h001F, 16'd1, 8'h00);
    wait_idle(1, "R4 single byte done");
    chk(expq.size() == 0, "R5 single byte stream", expq.size(), 0);

    // R8 read, with an ignored start in the middle (R1)
    push(8'h03); push(8'h12); push(8'h34);
    for (int i = 0; i < 5; i++) begin push(8'h00); rdq.push_back(mem_pat(16'h1234 + 16'(i))); end
    push_end();
    start_op(2'd1, 16'h1234, 16'd5, 8'h00);
    repeat (40) @(negedge clk);
    op = 2'd0; addr = 16'h0300; count = 16'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy kept after ignored start", busy, 1);
    wait_idle(1, "R8 read done");
    chk(expq.size() == 0, "R1 R8 read stream unchanged", expq.size(), 0);
    chk(rdq.size() == 0, "R8 all bytes delivered", rdq.size(), 0);

    // R9 status write
    push(8'h06); push_end(); push(8'h01); push(8'h10); push_end();
    start_op(2'd2, 16'h0000, 16'd0, 8'h10);
    wait_idle(1, "R9 status write done");
    chk(expq.size() == 0, "R9 status stream", expq.size(), 0);

    // R1 reserved op code ignored
    start_op(2'd3, 16'h0000, 16'd3, 8'h00);
    chk(busy == 1'b0 && done == 1'b0, "R1 reserved op ignored", {busy, done}, 0);
    repeat (50) @(negedge clk);
    chk(cs_n == 1'b1, "R1 reserved op no frame", cs_n, 1);

    // R12 zero count
    start_op(2'd0, 16'h0040, 16'd0, 8'h00);
    wait_idle(1, "R12 zero count done next cycle");
    start_op(2'd1, 16'h0040, 16'd0, 8'h00);
    wait_idle(1, "R12 zero count read done");
    chk(cs_n == 1'b1 && expq.size() == 0, "R12 no frame", cs_n, 1);

    // R6 poll limit exhausted
    busy_cfg = 1000;
    gen_write(16'h0040, 3, 1000);
    start_op(2'd0, 16'h0040, 16'd3, 8'h00);
    wait_idle(0, "R6 no done on give-up");
    chk(error == 1'b1, "R6 error raised", error, 1);
    chk(cs_n == 1'b1 && busy == 1'b0, "R6 bus released", {cs_n, busy}, 2'b10);
    repeat (200) @(negedge clk);
    chk(expq.size() == 0 && cs_n == 1'b1, "R6 no frames after give-up", expq.size(), 0);

    // R6 error cleared by the next start; R4 wrap across 0x7FFF/0x8000 pages
    busy_cfg = 0;
    gen_write(16'h7FFE, 4, 0);
    start_op(2'd0, 16'h7FFE, 16'd4, 8'h00);
    chk(error == 1'b0, "R6 error cleared on start", error, 0);
    wait_idle(1, "R4 split write done");
    chk(expq.size() == 0 && srcq.size() == 0, "R4 split stream", expq.size(), 0);

    finish_run();
  end
endmodule